// File: doc/BRIEF.md
# Correlator Signal Quality Estimator

This block watches the complex output of a spreading-code correlator. The correlator output arrives at twice the chip rate, which gives 22 samples per symbol. For every symbol the block takes the sample at the correlation peak as the on-time tap. It passes the neighbouring early and late taps on to a timing tracker. From the on-time taps it builds two measures of signal quality. The first is an integrated peak magnitude, where a larger value means a better signal. The second is the variance of the symbol-to-symbol phase step, where a smaller value means a better signal.

Taking the phase difference between successive on-time taps removes the phase flips that scrambling puts onto each symbol. An upstream stage supplies the phase of each sample as a wrapping signed value. The block reports the mean of the phase step as a phase rate. It reports the spread of the step as a phase noise measure. Integration runs over 16 symbols while the receiver is acquiring and over 128 symbols once it is demodulating data. At the end of each block a strobe lasting one cycle delivers the results.

Top module: `sq_estimator`

## Requirements
- R1: While `rst` is high at a clock edge, every output of the block is cleared to zero. This includes both strobes and all metrics.
- R2: A sample counts only in a cycle where `samp_vld` is high. A counted sample that has `sym_start` high takes position 0. Each following counted sample takes the next position. Cycles with `samp_vld` low leave the position unchanged. The position stops at 63. After reset the position starts at 63, so no symbol is produced until the first `sym_start`.
- R3: When the counted sample at position `peak_idx`+1 arrives, `sym_vld` goes high for one cycle at the next edge. `peak_idx` must lie in the range 1..20. At that point the late outputs hold this sample, the on-time outputs hold the sample at position `peak_idx`, and the early outputs hold the sample at position `peak_idx`-1. These tap outputs keep their values until the next symbol.
- R4: The magnitude of a symbol is |I|+|Q| of its on-time sample, with a range of 0..256. `amp_metric` is the sum of these magnitudes over the block, saturated at 65535.
- R5: The phase step of a symbol is its on-time phase minus the on-time phase of the symbol before it. The result wraps to a signed 8-bit value. The phase of the previous symbol carries across block boundaries and is 0 after reset. `sym_dphase` shows the step while `sym_vld` is high.
- R6: A block is 16 symbols long when `data_mode` is 0 and 128 symbols long when it is 1. The block samples `data_mode` only at the first symbol of each block. A change to `data_mode` in the middle of a block does not change the length of that block.
- R7: `rate_metric` is the floor of the block's sum of phase steps divided by the block length. It is a signed 8-bit value.
- R8: `var_metric` is floor((N·Σd² − (Σd)²) / N²), where d runs over the block's phase steps and N is the block length. It is saturated at 65535.
- R9: `blk_vld` pulses for one cycle in the cycle after the `sym_vld` of a block's last symbol. The three metrics update only at that pulse and hold their values between pulses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| samp_vld | input | 1 | Marks a correlator sample in this cycle |
| sym_start | input | 1 | The sample in this cycle is position 0 of a symbol |
| peak_idx | input | 5 | Position of the on-time sample within the symbol (1..20) |
| samp_i | input | 8 | Correlator output, in-phase, signed |
| samp_q | input | 8 | Correlator output, quadrature, signed |
| samp_phase | input | 8 | Phase of the sample, signed, wraps at ±π |
| data_mode | input | 1 | 0 selects 16-symbol blocks, 1 selects 128-symbol blocks |
| sym_vld | output | 1 | Strobe for a new set of taps |
| early_i | output | 8 | Early tap, in-phase |
| early_q | output | 8 | Early tap, quadrature |
| ontime_i | output | 8 | On-time tap, in-phase |
| ontime_q | output | 8 | On-time tap, quadrature |
| late_i | output | 8 | Late tap, in-phase |
| late_q | output | 8 | Late tap, quadrature |
| sym_dphase | output | 8 | Phase step of the current symbol, signed |
| blk_vld | output | 1 | Strobe for completed block metrics |
| amp_metric | output | 16 | Integrated on-time magnitude |
| var_metric | output | 16 | Variance of the phase step |
| rate_metric | output | 8 | Mean phase step, signed |

## Verification
Suppose the position counter or the history of taps goes wrong. The tap outputs would then be wrong at the very next `sym_vld`, one cycle after the late sample. An error in the stored previous phase would show up at once in `sym_dphase`, and at the end of the block in the rate and variance. A wrong block counter or a wrongly latched mode would only become visible when a block ends: `blk_vld` would arrive too early or too late, up to 128 symbols after the fault. The bench therefore compares every output on every cycle. It also places a mode change inside a block, so that a mode latched at the wrong time would move the strobe.

// File: rtl/sq_pkg.sv
package sq_pkg;

    localparam int SW = 8;   // sample width
    localparam int PW = 8;   // phase width
    localparam int MW = 16;  // metric width

    typedef logic signed [SW-1:0] smp_t;
    typedef logic signed [PW-1:0] ph_t;
    typedef logic [SW:0]          amp_t;

    typedef struct packed {
        smp_t i;
        smp_t q;
    } iq_t;

    typedef enum logic {
        MODE_ACQ  = 1'b0,
        MODE_DATA = 1'b1
    } mode_e;

    function automatic amp_t mag_l1(input smp_t i, input smp_t q);
        logic signed [SW:0] ei;
        logic signed [SW:0] eq;
        logic signed [SW:0] ai;
        logic signed [SW:0] aq;
        ei = {i[SW-1], i};
        eq = {q[SW-1], q};
        ai = ei[SW] ? -ei : ei;
        aq = eq[SW] ? -eq : eq;
        return amp_t'($unsigned(ai)) + amp_t'($unsigned(aq));
    endfunction

    function automatic ph_t wrap_diff(input ph_t a, input ph_t b);
        return a - b;
    endfunction

    function automatic logic [MW-1:0] sat_u(input logic [47:0] v);
        return (v > 48'(16'hFFFF)) ? '1 : v[MW-1:0];
    endfunction

endpackage

// File: rtl/sq_tap_select.sv
module sq_tap_select
    import sq_pkg::*;
#(
    parameter int SPS = 22
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     samp_vld,
    input  logic                     sym_start,
    input  logic [$clog2(SPS)-1:0]   peak_idx,
    input  iq_t                      cur_iq,
    input  ph_t                      cur_ph,
    output logic                     sym_vld,
    output iq_t                      early,
    output iq_t                      ontime,
    output iq_t                      late,
    output ph_t                      on_ph
);
    localparam int IW    = $clog2(SPS);
    localparam int POS_W = IW + 1;

    logic [POS_W-1:0] pos_q, pos_now;
    iq_t              h0_iq, h1_iq;
    ph_t              h0_ph;
    logic             hit;

    always_comb begin
        if (sym_start)
            pos_now = '0;
        else if (pos_q == '1)
            pos_now = pos_q;
        else
            pos_now = pos_q + POS_W'(1);
        hit = samp_vld && (pos_now == (POS_W'(peak_idx) + POS_W'(1)));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q   <= '1;
            h0_iq   <= '0;
            h1_iq   <= '0;
            h0_ph   <= '0;
            sym_vld <= 1'b0;
            early   <= '0;
            ontime  <= '0;
            late    <= '0;
            on_ph   <= '0;
        end else begin
            sym_vld <= hit;
            if (samp_vld) begin
                pos_q <= pos_now;
                h1_iq <= h0_iq;
                h0_iq <= cur_iq;
                h0_ph <= cur_ph;
            end
            if (hit) begin
                early  <= h1_iq;
                ontime <= h0_iq;
                on_ph  <= h0_ph;
                late   <= cur_iq;
            end
        end
    end

endmodule

// File: rtl/sq_block_integrator.sv
module sq_block_integrator
    import sq_pkg::*;
#(
    parameter int ACQ_LOG  = 4,
    parameter int DATA_LOG = 7
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          sym_vld,
    input  iq_t           on_iq,
    input  ph_t           on_ph,
    input  logic          data_mode,
    output ph_t           sym_dphase,
    output logic          blk_vld,
    output logic [MW-1:0] amp_metric,
    output logic [MW-1:0] var_metric,
    output ph_t           rate_metric
);
    localparam int ACQ_N  = 1 << ACQ_LOG;
    localparam int DATA_N = 1 << DATA_LOG;
    localparam int CW     = DATA_LOG;
    localparam int AW     = SW + 1 + DATA_LOG;
    localparam int DW     = PW + DATA_LOG;
    localparam int QW     = 2 * PW + DATA_LOG;
    localparam int VW     = 2 * PW + 2 * DATA_LOG + 2;

    logic [CW-1:0]          cnt_q;
    mode_e                  mode_q, mode_now;
    ph_t                    prev_q, dph, rate_v;
    logic signed [2*PW-1:0] dsq_s;
    logic [AW-1:0]          amp_q, amp_n;
    logic signed [DW-1:0]   sum_q, sum_n;
    logic [QW-1:0]          sq_q, sq_n;
    logic signed [VW-1:0]   sq_ext, sum_ext, num_v, var_v;
    logic                   first, last;
    int                     log_n;

    always_comb begin
        dph      = wrap_diff(on_ph, prev_q);
        dsq_s    = dph * dph;
        first    = (cnt_q == '0);
        mode_now = first ? mode_e'(data_mode) : mode_q;
        log_n    = (mode_now == MODE_DATA) ? DATA_LOG : ACQ_LOG;
        last     = (mode_now == MODE_DATA) ? (cnt_q == CW'(DATA_N - 1))
                                           : (cnt_q == CW'(ACQ_N - 1));
        amp_n    = (first ? '0 : amp_q) + AW'(mag_l1(on_iq.i, on_iq.q));
        sum_n    = (first ? '0 : sum_q) + DW'(dph);
        sq_n     = (first ? '0 : sq_q) + QW'($unsigned(dsq_s));
        sq_ext   = $signed(VW'(sq_n));
        sum_ext  = VW'(sum_n);
        num_v    = (sq_ext <<< log_n) - sum_ext * sum_ext;
        var_v    = num_v >>> (2 * log_n);
        rate_v   = PW'(sum_n >>> log_n);
    end

    assign sym_dphase = dph;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q       <= '0;
            mode_q      <= MODE_ACQ;
            prev_q      <= '0;
            amp_q       <= '0;
            sum_q       <= '0;
            sq_q        <= '0;
            blk_vld     <= 1'b0;
            amp_metric  <= '0;
            var_metric  <= '0;
            rate_metric <= '0;
        end else begin
            blk_vld <= 1'b0;
            if (sym_vld) begin
                prev_q <= on_ph;
                mode_q <= mode_now;
                if (last) begin
                    cnt_q       <= '0;
                    blk_vld     <= 1'b1;
                    amp_metric  <= sat_u(48'(amp_n));
                    var_metric  <= sat_u(48'(var_v));
                    rate_metric <= rate_v;
                end else begin
                    cnt_q <= cnt_q + CW'(1);
                    amp_q <= amp_n;
                    sum_q <= sum_n;
                    sq_q  <= sq_n;
                end
            end
        end
    end

endmodule

// File: rtl/sq_estimator.sv
module sq_estimator
    import sq_pkg::*;
#(
    parameter int SPS      = 22,
    parameter int ACQ_LOG  = 4,
    parameter int DATA_LOG = 7
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   samp_vld,
    input  logic                   sym_start,
    input  logic [$clog2(SPS)-1:0] peak_idx,
    input  logic signed [SW-1:0]   samp_i,
    input  logic signed [SW-1:0]   samp_q,
    input  logic signed [PW-1:0]   samp_phase,
    input  logic                   data_mode,
    output logic                   sym_vld,
    output logic signed [SW-1:0]   early_i,
    output logic signed [SW-1:0]   early_q,
    output logic signed [SW-1:0]   ontime_i,
    output logic signed [SW-1:0]   ontime_q,
    output logic signed [SW-1:0]   late_i,
    output logic signed [SW-1:0]   late_q,
    output logic signed [PW-1:0]   sym_dphase,
    output logic                   blk_vld,
    output logic [MW-1:0]          amp_metric,
    output logic [MW-1:0]          var_metric,
    output logic signed [PW-1:0]   rate_metric
);
    iq_t cur_iq, early, ontime, late;
    ph_t on_ph;

    assign cur_iq = '{i: samp_i, q: samp_q};

    sq_tap_select #(.SPS(SPS)) u_taps (
        .clk       (clk),
        .rst       (rst),
        .samp_vld  (samp_vld),
        .sym_start (sym_start),
        .peak_idx  (peak_idx),
        .cur_iq    (cur_iq),
        .cur_ph    (samp_phase),
        .sym_vld   (sym_vld),
        .early     (early),
        .ontime    (ontime),
        .late      (late),
        .on_ph     (on_ph)
    );

    sq_block_integrator #(.ACQ_LOG(ACQ_LOG), .DATA_LOG(DATA_LOG)) u_integ (
        .clk         (clk),
        .rst         (rst),
        .sym_vld     (sym_vld),
        .on_iq       (ontime),
        .on_ph       (on_ph),
        .data_mode   (data_mode),
        .sym_dphase  (sym_dphase),
        .blk_vld     (blk_vld),
        .amp_metric  (amp_metric),
        .var_metric  (var_metric),
        .rate_metric (rate_metric)
    );

    assign early_i  = early.i;
    assign early_q  = early.q;
    assign ontime_i = ontime.i;
    assign ontime_q = ontime.q;
    assign late_i   = late.i;
    assign late_q   = late.q;

endmodule

// File: rtl/sq_estimator_chk.sv
module sq_estimator_chk
    import sq_pkg::*;
(
    input logic          clk,
    input logic          rst,
    input smp_t          samp_i,
    input logic          sym_vld,
    input smp_t          late_i,
    input logic          blk_vld,
    input logic [MW-1:0] amp_metric,
    input logic [MW-1:0] var_metric
);
    // R3
    sym_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        sym_vld |=> !sym_vld);

    // R3
    late_tap_chk: assert property (@(posedge clk) disable iff (rst)
        sym_vld |-> late_i == $past(samp_i));

    // R9
    blk_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        blk_vld |=> !blk_vld);

    // R9
    blk_after_sym_chk: assert property (@(posedge clk) disable iff (rst)
        blk_vld |-> $past(sym_vld));

    // R9
    metric_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !blk_vld |-> ($stable(amp_metric) && $stable(var_metric)));

    // R8
    var_bound_chk: assert property (@(posedge clk) disable iff (rst)
        blk_vld |-> var_metric <= 16'd16384);

endmodule

bind sq_estimator sq_estimator_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .samp_i     (samp_i),
    .sym_vld    (sym_vld),
    .late_i     (late_i),
    .blk_vld    (blk_vld),
    .amp_metric (amp_metric),
    .var_metric (var_metric)
);

// File: tb/tb_sq_estimator.sv
module tb_sq_estimator;

    logic              clk = 1'b0;
    logic              rst;
    logic              samp_vld, sym_start, data_mode;
    logic [4:0]        peak_idx;
    logic signed [7:0] samp_i, samp_q, samp_phase;
    logic              sym_vld, blk_vld;
    logic signed [7:0] early_i, early_q, ontime_i, ontime_q, late_i, late_q;
    logic signed [7:0] sym_dphase, rate_metric;
    logic [15:0]       amp_metric, var_metric;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  finished = 0;
    int  cur_peak = 10;
    bit  want_mode = 0;

    // reference model state
    int  m_pos, m_prev, m_cnt, m_n;
    bit  m_mode;
    longint s_amp, s_d, s_d2;
    int  h0i, h0q, h0p, h1i, h1q;
    bit  e_sym, e_blk;
    int  e_ei, e_eq, e_oi, e_oq, e_op, e_li, e_lq;
    int  e_amp, e_var, e_rate;

    always #5 clk = ~clk;

    sq_estimator dut (
        .clk(clk), .rst(rst), .samp_vld(samp_vld), .sym_start(sym_start),
        .peak_idx(peak_idx), .samp_i(samp_i), .samp_q(samp_q),
        .samp_phase(samp_phase), .data_mode(data_mode),
        .sym_vld(sym_vld), .early_i(early_i), .early_q(early_q),
        .ontime_i(ontime_i), .ontime_q(ontime_q), .late_i(late_i),
        .late_q(late_q), .sym_dphase(sym_dphase), .blk_vld(blk_vld),
        .amp_metric(amp_metric), .var_metric(var_metric),
        .rate_metric(rate_metric)
    );

    function automatic int w8(int x);
        int y;
        y = x & 255;
        return (y >= 128) ? y - 256 : y;
    endfunction

    function automatic int iabs(int x);
        return (x < 0) ? -x : x;
    endfunction

    function automatic int rnd8();
        return int'($urandom_range(255)) - 128;
    endfunction

    task automatic chk(string tag, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare();
        chk("R2 R3 sym_vld", int'(sym_vld), int'(e_sym));
        if (e_sym) begin
            chk("R3 early_i", int'(early_i), e_ei);
            chk("R3 early_q", int'(early_q), e_eq);
            chk("R3 ontime_i", int'(ontime_i), e_oi);
            chk("R3 ontime_q", int'(ontime_q), e_oq);
            chk("R3 late_i", int'(late_i), e_li);
            chk("R3 late_q", int'(late_q), e_lq);
            chk("R5 sym_dphase", int'(sym_dphase), w8(e_op - m_prev));
        end
        chk("R6 R9 blk_vld", int'(blk_vld), int'(e_blk));
        chk("R4 amp_metric", int'(amp_metric), e_amp);
        chk("R8 var_metric", int'(var_metric), e_var);
        chk("R7 rate_metric", int'(rate_metric), e_rate);
    endtask

    task automatic model_reset();
        m_pos = 63; m_prev = 0; m_cnt = 0; m_n = 16; m_mode = 0;
        s_amp = 0; s_d = 0; s_d2 = 0;
        h0i = 0; h0q = 0; h0p = 0; h1i = 0; h1q = 0;
        e_sym = 0; e_blk = 0;
        e_ei = 0; e_eq = 0; e_oi = 0; e_oq = 0; e_op = 0; e_li = 0; e_lq = 0;
        e_amp = 0; e_var = 0; e_rate = 0;
    endtask

    task automatic model_step(bit v, bit s, int i, int q, int p);
        int d, posnow;
        longint num, qt;
        // block integration driven by the current symbol strobe
        e_blk = 0;
        if (e_sym) begin
            d = w8(e_op - m_prev);
            if (m_cnt == 0) begin
                m_mode = want_mode;
                s_amp = 0; s_d = 0; s_d2 = 0;
            end
            m_n = m_mode ? 128 : 16;
            s_amp += iabs(e_oi) + iabs(e_oq);
            s_d   += d;
            s_d2  += d * d;
            m_cnt++;
            m_prev = e_op;
            if (m_cnt == m_n) begin
                m_cnt = 0;
                e_blk = 1;
                e_amp = (s_amp > 65535) ? 65535 : int'(s_amp);
                qt = s_d / m_n;
                if ((s_d % m_n) != 0 && s_d < 0) qt = qt - 1;
                e_rate = w8(int'(qt));
                num = longint'(m_n) * s_d2 - s_d * s_d;
                qt = num / (longint'(m_n) * m_n);
                e_var = (qt > 65535) ? 65535 : int'(qt);
            end
        end
        // tap selection
        e_sym = 0;
        if (v) begin
            posnow = s ? 0 : ((m_pos == 63) ? 63 : m_pos + 1);
            if (posnow == cur_peak + 1) begin
                e_sym = 1;
                e_ei = h1i; e_eq = h1q;
                e_oi = h0i; e_oq = h0q; e_op = h0p;
                e_li = i;   e_lq = q;
            end
            h1i = h0i; h1q = h0q;
            h0i = i; h0q = q; h0p = p;
            m_pos = posnow;
        end
    endtask

    task automatic drive(bit v, bit s, int i, int q, int p);
        @(negedge clk);
        compare();
        samp_vld   = v;
        sym_start  = s;
        samp_i     = 8'(i);
        samp_q     = 8'(q);
        samp_phase = 8'(p);
        peak_idx   = 5'(cur_peak);
        data_mode  = want_mode;
        model_step(v, s, w8(i), w8(q), w8(p));
    endtask

    task automatic send_sym(int on_ph, bit gaps);
        for (int k = 0; k < 22; k++) begin
            if (gaps && (k % 4 == 2)) drive(0, 0, rnd8(), rnd8(), rnd8()); // R2 idle cycle
            drive(1, k == 0, rnd8(), rnd8(), (k == cur_peak) ? on_ph : rnd8());
        end
    endtask

    int ph_acc = 0;

    task automatic run_syms(int nsym, int step, int noise, bit gaps);
        for (int n = 0; n < nsym; n++) begin
            ph_acc += step;
            if (noise > 0) ph_acc += int'($urandom_range(2 * noise)) - noise;
            send_sym(w8(ph_acc), gaps);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(17));
        rst = 1; samp_vld = 0; sym_start = 0; samp_i = 0; samp_q = 0;
        samp_phase = 0; data_mode = 0; peak_idx = 5'd10;
        model_reset();
        repeat (3) @(negedge clk);
        // R1: reset state at the ports
        chk("R1 sym_vld", int'(sym_vld), 0);
        chk("R1 blk_vld", int'(blk_vld), 0);
        chk("R1 ontime_i", int'(ontime_i), 0);
        chk("R1 amp_metric", int'(amp_metric), 0);
        chk("R1 var_metric", int'(var_metric), 0);
        chk("R1 rate_metric", int'(rate_metric), 0);
        rst = 0;
        model_step(0, 0, 0, 0, 0);

        // R2: samples before any symbol start produce no symbol
        for (int k = 0; k < 30; k++) drive(1, 0, rnd8(), rnd8(), rnd8());

        // acquisition block, slow rate with noise
        cur_peak = 10; want_mode = 0;
        run_syms(16, 5, 3, 0);
        // acquisition block, wrapping rate, idle gaps, early peak
        cur_peak = 1;
        run_syms(16, 100, 6, 1);
        // R6: mode raised mid-block, block still 16 long; late peak
        cur_peak = 20;
        run_syms(4, -7, 20, 0);
        want_mode = 1;
        run_syms(12, -7, 20, 0);
        // data block of 128, mode dropped part way through
        cur_peak = 7;
        run_syms(50, 33, 40, 0);
        want_mode = 0;
        run_syms(78, 33, 40, 0);
        // back to acquisition, wide phase spread
        cur_peak = 12;
        run_syms(16, 0, 127, 1);
        for (int k = 0; k < 5; k++) drive(0, 0, 0, 0, 0);
        @(negedge clk);
        compare();

        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

endmodule